// File: doc/BRIEF.md
# Floating-Point Register Constant Expander

This block turns a short immediate into a full 64-bit floating-point register value in one clocked step. A two-bit selector picks one of four packing modes. Two modes are integer-style placements of a word: a sign-extended load into the low half, or a load into the high half with a fill pattern below it. The other two modes are packed SIMD constants: two half-precision values widened to two single-precision lanes, or four 8-bit floats widened to four half-precision lanes. A separate scalar flag ignores the selector and widens one half-precision value to double precision.

The lane widening is done by one generic, exact widening converter. It is instantiated in lane banks, the same arrangement a vector format-conversion path would use, so the constant path needs no conversion logic of its own. The output is registered. A result appears one cycle after its input strobe and then stays in place until the next strobe.

Top module: `fpimm_expand`

## Requirements
- R1: Mode 0 (selector 2'b00, scalar flag low) outputs the 33-bit signed immediate sign-extended to 64 bits: bits 32:0 are the immediate and bits 63:33 are copies of immediate bit 32.
- R2: Mode 1 (selector 2'b01) puts immediate bits 31:0 in output bits 63:32, and fills every one of output bits 31:0 with immediate bit 32.
- R3: Mode 2 (selector 2'b10) widens immediate bits 15:0 (binary16) to binary32 in output bits 31:0, and immediate bits 31:16 to binary32 in output bits 63:32.
- R4: Mode 3 (selector 2'b11) reads byte k of the immediate (bits 8k+7:8k) as an 8-bit float and writes its binary16 widening to output bits 16k+15:16k, for k = 0..3. The 8-bit float is sign in bit 7, a 4-bit exponent with bias 7 in bits 6:3, and a 3-bit mantissa in bits 2:0. The exponent is rebiased to 15.
- R5: When the scalar flag is high, the selector and immediate bits 32:16 have no effect, and the output is immediate bits 15:0 widened from binary16 to binary64.
- R6: Every widening keeps the sign, and a zero of either sign becomes a zero of the same sign.
- R7: Subnormal inputs are normalised: the output holds the exact value as a normal number in the wider format.
- R8: An all-ones input exponent gives an all-ones output exponent. The input mantissa is placed in the top bits of the output mantissa and the lower bits are zero, so infinity stays infinity and a NaN keeps its payload.
- R9: out_valid is high in exactly the cycles that follow a cycle with in_valid high.
- R10: After a cycle with in_valid low, out_data is unchanged, whatever the other inputs do.
- R11: Synchronous reset clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_mode | input | 2 | Packing mode selector |
| in_imm | input | 33 | Immediate; bit 32 is the extra sign bit |
| in_scalar | input | 1 | Selects the scalar half-to-double widening |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Expanded register value |

## Verification
The scalar path is swept over all 65,536 half-precision codes, with the upper immediate bits and the selector scrambled so that any leak from them would change the result. The dual-lane mode is also swept over every half code in each lane, with the second lane XOR-scrambled so that a lane swap or cross-lane mix-up shows. The quad-lane mode walks all 256 byte codes through four differently permuted lanes, which covers zeros, subnormals, infinities and NaNs in every lane position. Walking-one and walking-zero immediates in the two integer modes separate sign-extension and fill errors from placement errors. Idle gaps with changing inputs show whether the output register holds its value and whether the strobe latency is right.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;

    typedef enum logic [1:0] {
        MODE_LO_SEXT = 2'b00,
        MODE_HI_FILL = 2'b01,
        MODE_H2S     = 2'b10,
        MODE_Q2H     = 2'b11
    } imm_mode_e;

    localparam int IMM_W   = 33;
    localparam int REG_W   = 64;

    // 8-bit float: 1 sign, 4 exponent, 3 mantissa
    localparam int Q_EXP   = 4;
    localparam int Q_MAN   = 3;
    localparam int H_EXP   = 5;
    localparam int H_MAN   = 10;
    localparam int S_EXP   = 8;
    localparam int S_MAN   = 23;
    localparam int D_EXP   = 11;
    localparam int D_MAN   = 52;

    localparam int Q_W     = 1 + Q_EXP + Q_MAN;
    localparam int H_W     = 1 + H_EXP + H_MAN;
    localparam int S_W     = 1 + S_EXP + S_MAN;
    localparam int D_W     = 1 + D_EXP + D_MAN;

    localparam int Q_LANES = REG_W / H_W;
    localparam int H_LANES = REG_W / S_W;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] data;
    } exp_out_t;

    function automatic logic [REG_W-1:0] place_low_sext(input logic [IMM_W-1:0] imm);
        return {{(REG_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [REG_W-1:0] place_high_fill(input logic [IMM_W-1:0] imm);
        return {imm[31:0], {32{imm[IMM_W-1]}}};
    endfunction

endpackage

// File: rtl/fp_widen.sv
module fp_widen #(
    parameter int IE = 5,
    parameter int IM = 10,
    parameter int OE = 8,
    parameter int OM = 23
) (
    input  logic [IE+IM:0] src,
    output logic [OE+OM:0] dst
);
    localparam int IBIAS = (1 << (IE - 1)) - 1;
    localparam int OBIAS = (1 << (OE - 1)) - 1;
    localparam int PADW  = OM - IM;
    localparam int LPW   = $clog2(IM) + 1;

    logic          sgn;
    logic [IE-1:0] exp_i;
    logic [IM-1:0] man_i;
    logic [LPW-1:0] lead;
    logic [IM-1:0] man_norm;
    logic [OE-1:0] exp_o;
    logic [IM-1:0] man_o;

    assign sgn   = src[IE+IM];
    assign exp_i = src[IE+IM-1:IM];
    assign man_i = src[IM-1:0];

    // highest set mantissa bit, used to normalise subnormals
    always_comb begin
        lead = '0;
        for (int b = 0; b < IM; b++) begin
            if (man_i[b]) lead = LPW'(b);
        end
    end

    assign man_norm = man_i << (LPW'(IM) - lead);

    always_comb begin
        if (exp_i == '1) begin
            exp_o = '1;
            man_o = man_i;
        end else if (exp_i == '0 && man_i == '0) begin
            exp_o = '0;
            man_o = '0;
        end else if (exp_i == '0) begin
            exp_o = OE'(OBIAS - IBIAS - IM + 1) + OE'(lead);
            man_o = man_norm;
        end else begin
            exp_o = OE'(exp_i) + OE'(OBIAS - IBIAS);
            man_o = man_i;
        end
    end

    assign dst = {sgn, exp_o, man_o, {PADW{1'b0}}};

    always_comb begin
        AST_SIGN_KEEP: assert (dst[OE+OM] == src[IE+IM]); // R6
        if (exp_i == '1) begin
            AST_SPECIAL_EXP: assert (dst[OE+OM-1:OM] == '1); // R8
        end
        if (exp_i == '0 && man_i != '0) begin
            AST_SUBN_NORMAL: assert (dst[OE+OM-1:OM] != '0); // R7
        end
    end

endmodule

// File: rtl/fp_widen_bank.sv
module fp_widen_bank #(
    parameter int LANES = 2,
    parameter int IE    = 5,
    parameter int IM    = 10,
    parameter int OE    = 8,
    parameter int OM    = 23
) (
    input  logic [LANES*(1+IE+IM)-1:0] src,
    output logic [LANES*(1+OE+OM)-1:0] dst
);
    localparam int IW = 1 + IE + IM;
    localparam int OW = 1 + OE + OM;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fp_widen #(.IE(IE), .IM(IM), .OE(OE), .OM(OM)) u_widen (
            .src(src[g*IW +: IW]),
            .dst(dst[g*OW +: OW])
        );
    end

endmodule

// File: rtl/fpimm_expand.sv
module fpimm_expand
    import fpimm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [IMM_W-1:0] in_imm,
    input  logic             in_scalar,
    output logic             out_valid,
    output logic [REG_W-1:0] out_data
);
    logic [REG_W-1:0] h2s_lanes;
    logic [REG_W-1:0] q2h_lanes;
    logic [D_W-1:0]   h2d_val;
    logic [REG_W-1:0] next_data;
    imm_mode_e        mode;
    exp_out_t         out_q;

    assign mode = imm_mode_e'(in_mode);

    fp_widen_bank #(.LANES(H_LANES), .IE(H_EXP), .IM(H_MAN), .OE(S_EXP), .OM(S_MAN)) u_h2s (
        .src(in_imm[H_LANES*H_W-1:0]),
        .dst(h2s_lanes)
    );

    fp_widen_bank #(.LANES(Q_LANES), .IE(Q_EXP), .IM(Q_MAN), .OE(H_EXP), .OM(H_MAN)) u_q2h (
        .src(in_imm[Q_LANES*Q_W-1:0]),
        .dst(q2h_lanes)
    );

    fp_widen #(.IE(H_EXP), .IM(H_MAN), .OE(D_EXP), .OM(D_MAN)) u_h2d (
        .src(in_imm[H_W-1:0]),
        .dst(h2d_val)
    );

    always_comb begin
        if (in_scalar) begin
            next_data = h2d_val;
        end else begin
            unique case (mode)
                MODE_LO_SEXT: next_data = place_low_sext(in_imm);
                MODE_HI_FILL: next_data = place_high_fill(in_imm);
                MODE_H2S:     next_data = h2s_lanes;
                MODE_Q2H:     next_data = q2h_lanes;
                default:      next_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) out_q.data <= next_data;
        end
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;

    AST_STROBE_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data)); // R10
    AST_LO_SEXT_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && in_mode == 2'b00) |=> out_data[63:32] == {32{$past(in_imm[32])}}); // R1
    AST_HI_PLACE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_scalar && in_mode == 2'b01) |=> out_data[63:32] == $past(in_imm[31:0])); // R2

endmodule

// File: tb/sim_fpimm_expand.sv
module sim_fpimm_expand;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'b00;
    logic [32:0] in_imm = '0;
    logic        in_scalar = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    fpimm_expand u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_imm(in_imm), .in_scalar(in_scalar),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (got cycle %0d, expected < 195000)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // arithmetic reference: exact widening by shift-until-normal
    function automatic logic [63:0] ref_widen(logic [63:0] v, int ie, int im, int oe, int om);
        int ibias = (1 << (ie - 1)) - 1;
        int obias = (1 << (oe - 1)) - 1;
        logic s = v[ie + im];
        int e = int'((v >> im) & ((64'd1 << ie) - 1));
        int m = int'(v & ((64'd1 << im) - 1));
        int ex;
        logic [63:0] fr;
        if (e == (1 << ie) - 1) begin
            ex = (1 << oe) - 1;
            fr = 64'(m) << (om - im);
        end else if (e == 0 && m == 0) begin
            ex = 0;
            fr = '0;
        end else if (e == 0) begin
            int mm = m;
            int ee = 1 - ibias;
            while (mm < (1 << im)) begin
                mm = mm * 2;
                ee = ee - 1;
            end
            ex = ee + obias;
            fr = 64'(mm - (1 << im)) << (om - im);
        end else begin
            ex = e - ibias + obias;
            fr = 64'(m) << (om - im);
        end
        return (64'(s) << (oe + om)) | (64'(ex) << om) | fr;
    endfunction

    function automatic logic [15:0] q2h(logic [7:0] b);
        return 16'(ref_widen(64'(b), 4, 3, 5, 10));
    endfunction

    function automatic logic [31:0] h2s(logic [15:0] h);
        return 32'(ref_widen(64'(h), 5, 10, 8, 23));
    endfunction

    task automatic check(string tag, logic [64:0] got, logic [64:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got v=%0b %h, expected v=%0b %h", tag, got[64], got[63:0], exp[64], exp[63:0]);
        end
    endtask

    // apply one vector at a falling edge, sample at the next falling edge
    task automatic apply(logic v, logic [1:0] md, logic [32:0] imm, logic sc);
        in_valid = v; in_mode = md; in_imm = imm; in_scalar = sc;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset state", {out_valid, out_data}, 65'd0);

        // R1: walking one and walking zero
        for (int k = 0; k < 33; k++) begin
            logic [32:0] a = 33'd1 << k;
            apply(1'b1, 2'b00, a, 1'b0);
            check("R1 low sext", {out_valid, out_data}, {1'b1, {31{a[32]}}, a});
            apply(1'b1, 2'b00, ~a, 1'b0);
            check("R1 low sext", {out_valid, out_data}, {1'b1, {31{~a[32]}}, ~a});
        end

        // R2
        for (int k = 0; k < 33; k++) begin
            logic [32:0] a = 33'd1 << k;
            apply(1'b1, 2'b01, a, 1'b0);
            check("R2 high fill", {out_valid, out_data}, {1'b1, a[31:0], {32{a[32]}}});
            apply(1'b1, 2'b01, ~a, 1'b0);
            check("R2 high fill", {out_valid, out_data}, {1'b1, ~a[31:0], {32{~a[32]}}});
        end

        // R3 with R6/R7/R8: every half code in each lane
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] l0 = 16'(i);
            logic [15:0] l1 = 16'(i) ^ 16'hA5C3;
            apply(1'b1, 2'b10, {1'(i), l1, l0}, 1'b0);
            check("R3/R6/R7/R8 dual half->single", {out_valid, out_data}, {1'b1, h2s(l1), h2s(l0)});
        end

        // R4 with R6/R7/R8: all byte codes in every lane
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b0 = 8'(i);
            logic [7:0] b1 = 8'(i) ^ 8'h5A;
            logic [7:0] b2 = ~8'(i);
            logic [7:0] b3 = 8'(i) + 8'd37;
            apply(1'b1, 2'b11, {1'b1, b3, b2, b1, b0}, 1'b0);
            check("R4/R6/R7/R8 quad 8bit->half", {out_valid, out_data},
                  {1'b1, q2h(b3), q2h(b2), q2h(b1), q2h(b0)});
        end

        // R5 with R6/R7/R8: scalar, selector and upper bits scrambled
        for (int i = 0; i < 65536; i++) begin
            logic [16:0] junk = 17'(i * 7919 + 13);
            apply(1'b1, 2'(i), {junk, 16'(i)}, 1'b1);
            check("R5/R6/R7/R8 scalar half->double", {out_valid, out_data},
                  {1'b1, ref_widen(64'(i), 5, 10, 11, 52)});
        end

        // R9/R10: known value, then idle cycles with changing inputs
        apply(1'b1, 2'b01, 33'h1_2345_6789, 1'b0);
        check("R9 strobe after valid", {out_valid, out_data}, {1'b1, 64'h2345_6789_FFFF_FFFF});
        for (int k = 0; k < 4; k++) begin
            apply(1'b0, 2'(k), 33'(k * 33'h0_1111_1111), 1'(k));
            check("R9/R10 idle hold", {out_valid, out_data}, {1'b0, 64'h2345_6789_FFFF_FFFF});
        end
        apply(1'b1, 2'b00, 33'h0_0000_0005, 1'b0);
        check("R9 strobe after gap", {out_valid, out_data}, {1'b1, 64'd5});

        // R11: reset mid-stream
        rst = 1'b1;
        apply(1'b0, 2'b00, '0, 1'b0);
        rst = 1'b0;
        check("R11 reset clears", {out_valid, out_data}, 65'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule